// File: doc/BRIEF.md
# Counting Semaphore Cell for Hardware Threads

This block holds one counting semaphore that several hardware threads share through a request bus. A read request is a P operation: it returns the current count and then lowers it by one. A write request is a V operation: it raises the count by one. Each request names the issuing thread and one of two views. The synchronized view parks a reader when the count is zero. The try view never parks anyone.

A parked thread is marked in a per-thread blocked bitmap. It stays parked until a later V operation frees it. At that point the block sends a wake response to that thread, carrying the count it was granted. The cell also has Empty and Full tag bits, which come out as ports. Semaphore traffic never changes them.

Every response is registered and appears exactly one clock after the request is sampled. The blocked bitmap and the count update on that same edge.

Top module: `semCell`

## Requirements
- R1: After reset the count is 0, the blocked bitmap is all zero, respValid and wakeValid are low, tagEmpty equals parameter TAG_EMPTY_INIT (default 1) and tagFull equals TAG_FULL_INIT (default 0).
- R2: A read (reqWrite=0) from an unblocked thread while the count is nonzero gives, one cycle later, respValid=1, respStall=0, respThread = the requester and respData = the count before the read. The count then drops by one. This holds in both views.
- R3: A read with reqTryView=1 while the count is zero gives, one cycle later, respValid=1, respStall=0 and respData=0. The count stays 0 and no blocked bit is set.
- R4: A read with reqTryView=0 while the count is zero gives, one cycle later, respValid=1, respStall=1 and respData=0. On that same edge, blockedMask bit <thread id> is set. While any bit of blockedMask is set, the count is 0.
- R5: A write from an unblocked thread gives, one cycle later, respValid=1, respStall=0 and respData=0. The value on reqData has no effect: each write adds exactly one.
- R6: A write when the count is 0xFFFF leaves it at 0xFFFF.
- R7: A write while any blocked bit is set frees the lowest-numbered blocked thread. One cycle later wakeValid=1, wakeThread is that thread and wakeData=1 (the count after the increment). Its blocked bit clears on the same edge, and the count stays 0 because the grant consumes the increment.
- R8: A request whose reqThread has its blocked bit set is dropped. It gives no response and no wake, and it changes neither the count nor the bitmap.
- R9: tagEmpty and tagFull never change after reset, whatever the requests are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe, one request per cycle |
| reqThread | input | TID_W | Issuing thread id |
| reqWrite | input | 1 | 1 = V (increment), 0 = P (read and decrement) |
| reqTryView | input | 1 | 1 = try view (never parks), 0 = synchronized view |
| reqData | input | CNT_W | Write data, ignored |
| respValid | output | 1 | Response to the request of the previous cycle |
| respThread | output | TID_W | Thread the response belongs to |
| respStall | output | 1 | 1 = reader parked, result follows on the wake port |
| respData | output | CNT_W | Read result; 0 for writes, try-misses and parks |
| wakeValid | output | 1 | A parked thread is released |
| wakeThread | output | TID_W | Released thread id |
| wakeData | output | CNT_W | Count granted to the released thread |
| blockedMask | output | 2**TID_W | One bit per thread that is currently parked |
| tagEmpty | output | 1 | Cell tag Empty bit |
| tagFull | output | 1 | Cell tag Full bit |

## Verification
A wrong internal count shows at the ports on the next read. That read returns a value one step off, or it parks when it should return. A missing saturation shows as a wrap to zero after 65536 writes. A bitmap that is wrong in either direction shows in the same cycle on blockedMask, and after the next write as a wake that goes to the wrong thread or never arrives. A reference model tracks the count and the parked set on every clock, so any such divergence is caught within one cycle of the request that exposes it.

// File: rtl/semCell_pkg.sv
`timescale 1ns/1ps
package semCell_pkg;

  // Per-cycle action strobes from the control to the datapath
  typedef struct packed {
    logic respond;    // emit a response next cycle
    logic stall;      // response marks the reader as parked
    logic giveCount;  // response carries the current count
    logic dec;        // P operation consumes one unit
    logic inc;        // V operation adds one unit (saturating)
    logic wake;       // V operation is handed to a parked thread
  } semStrobes_t;

endpackage

// File: rtl/semCtrl.sv
`timescale 1ns/1ps
module semCtrl
  import semCell_pkg::*;
#(
  parameter int TID_W = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [TID_W-1:0]       reqThread,
  input  logic                   reqWrite,
  input  logic                   reqTryView,
  input  logic                   cntZero,
  output semStrobes_t            strobes,
  output logic [TID_W-1:0]       wakeTid,
  output logic [(1<<TID_W)-1:0]  blockedMask
);
  localparam int THREADS = 1 << TID_W;

  logic [THREADS-1:0] blockedQ, blockedD;
  logic               anyBlocked;
  logic [TID_W-1:0]   lowTid;
  logic               accept, isRead;

  // lowest-numbered parked thread wins the next grant
  always_comb begin
    lowTid = '0;
    for (int i = THREADS - 1; i >= 0; i--) begin
      if (blockedQ[i]) lowTid = TID_W'(i);
    end
  end
  assign anyBlocked = |blockedQ;

  assign accept = reqValid && !blockedQ[reqThread];
  assign isRead = accept && !reqWrite;

  always_comb begin
    strobes           = '0;
    strobes.respond   = accept;
    strobes.giveCount = isRead && !cntZero;
    strobes.dec       = isRead && !cntZero;
    strobes.stall     = isRead && cntZero && !reqTryView;
    strobes.wake      = accept && reqWrite && anyBlocked;
    strobes.inc       = accept && reqWrite && !anyBlocked;
  end

  always_comb begin
    blockedD = blockedQ;
    if (strobes.stall) blockedD[reqThread] = 1'b1;
    if (strobes.wake)  blockedD[lowTid]    = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) blockedQ <= '0;
    else       blockedQ <= blockedD;
  end

  assign wakeTid     = lowTid;
  assign blockedMask = blockedQ;
endmodule

// File: rtl/semDatapath.sv
`timescale 1ns/1ps
module semDatapath
  import semCell_pkg::*;
#(
  parameter int   TID_W          = 2,
  parameter int   CNT_W          = 16,
  parameter logic TAG_EMPTY_INIT = 1'b1,
  parameter logic TAG_FULL_INIT  = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  semStrobes_t        strobes,
  input  logic [TID_W-1:0]   reqThread,
  input  logic [TID_W-1:0]   wakeTid,
  input  logic [CNT_W-1:0]   reqData,
  output logic               cntZero,
  output logic [CNT_W-1:0]   cntQ,
  output logic               respValid,
  output logic [TID_W-1:0]   respThread,
  output logic               respStall,
  output logic [CNT_W-1:0]   respData,
  output logic               wakeValid,
  output logic [TID_W-1:0]   wakeThread,
  output logic [CNT_W-1:0]   wakeData,
  output logic               tagEmpty,
  output logic               tagFull
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic cntMax;
  logic unusedData;

  assign cntZero    = (cntQ == '0);
  assign cntMax     = (cntQ == CNT_MAX);
  assign unusedData = ^reqData;  // V operations carry no payload

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ       <= '0;
      respValid  <= 1'b0;
      respThread <= '0;
      respStall  <= 1'b0;
      respData   <= '0;
      wakeValid  <= 1'b0;
      wakeThread <= '0;
      wakeData   <= '0;
    end else begin
      respValid <= strobes.respond;
      respStall <= strobes.stall;
      wakeValid <= strobes.wake;
      if (strobes.respond) begin
        respThread <= reqThread;
        respData   <= strobes.giveCount ? cntQ : '0;
      end
      if (strobes.wake) begin
        wakeThread <= wakeTid;
        wakeData   <= cntQ + CNT_W'(1);
      end
      if (strobes.dec)                 cntQ <= cntQ - CNT_W'(1);
      else if (strobes.inc && !cntMax) cntQ <= cntQ + CNT_W'(1);
    end
  end

  // tag bits: fixed by reset, untouched by semaphore traffic
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagEmpty <= TAG_EMPTY_INIT;
      tagFull  <= TAG_FULL_INIT;
    end else begin
      tagEmpty <= tagEmpty;
      tagFull  <= tagFull;
    end
  end
endmodule

// File: rtl/semCell.sv
`timescale 1ns/1ps
module semCell
  import semCell_pkg::*;
#(
  parameter int   TID_W          = 2,
  parameter int   CNT_W          = 16,
  parameter logic TAG_EMPTY_INIT = 1'b1,
  parameter logic TAG_FULL_INIT  = 1'b0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [TID_W-1:0]       reqThread,
  input  logic                   reqWrite,
  input  logic                   reqTryView,
  input  logic [CNT_W-1:0]       reqData,
  output logic                   respValid,
  output logic [TID_W-1:0]       respThread,
  output logic                   respStall,
  output logic [CNT_W-1:0]       respData,
  output logic                   wakeValid,
  output logic [TID_W-1:0]       wakeThread,
  output logic [CNT_W-1:0]       wakeData,
  output logic [(1<<TID_W)-1:0]  blockedMask,
  output logic                   tagEmpty,
  output logic                   tagFull
);
  semStrobes_t      strobes;
  logic [TID_W-1:0] wakeTid;
  logic             cntZero;
  logic [CNT_W-1:0] cntQ;

  semCtrl #(.TID_W(TID_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqThread(reqThread),
    .reqWrite(reqWrite), .reqTryView(reqTryView), .cntZero(cntZero),
    .strobes(strobes), .wakeTid(wakeTid), .blockedMask(blockedMask)
  );

  semDatapath #(
    .TID_W(TID_W), .CNT_W(CNT_W),
    .TAG_EMPTY_INIT(TAG_EMPTY_INIT), .TAG_FULL_INIT(TAG_FULL_INIT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqThread(reqThread),
    .wakeTid(wakeTid), .reqData(reqData), .cntZero(cntZero), .cntQ(cntQ),
    .respValid(respValid), .respThread(respThread), .respStall(respStall),
    .respData(respData), .wakeValid(wakeValid), .wakeThread(wakeThread),
    .wakeData(wakeData), .tagEmpty(tagEmpty), .tagFull(tagFull)
  );
endmodule

// File: rtl/semCell_chk.sv
`timescale 1ns/1ps
module semCell_chk #(
  parameter int TID_W = 2,
  parameter int CNT_W = 16
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   reqValid,
  input logic [TID_W-1:0]       reqThread,
  input logic                   reqWrite,
  input logic                   reqTryView,
  input logic                   respValid,
  input logic [TID_W-1:0]       respThread,
  input logic                   respStall,
  input logic [CNT_W-1:0]       respData,
  input logic                   wakeValid,
  input logic [TID_W-1:0]       wakeThread,
  input logic [CNT_W-1:0]       wakeData,
  input logic [(1<<TID_W)-1:0]  blockedMask,
  input logic                   tagEmpty,
  input logic                   tagFull,
  input logic [CNT_W-1:0]       cntQ
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  AST_READ_DECREMENTS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && !blockedMask[reqThread] && cntQ != '0)
    |=> (cntQ == $past(cntQ) - CNT_W'(1)) && (respData == $past(cntQ)) && !respStall); // R2

  AST_TRY_NEVER_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqTryView) |=> !respStall); // R3

  AST_STALL_MARKS_THREAD: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respStall) |-> blockedMask[respThread] && (respData == '0)); // R4

  AST_PARKED_ONLY_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (|blockedMask) |-> (cntQ == '0)); // R4

  AST_WRITE_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !blockedMask[reqThread])
    |=> respValid && !respStall && (respData == '0)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && cntQ == CNT_MAX) |=> (cntQ == CNT_MAX)); // R6

  AST_WAKE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    wakeValid |-> !blockedMask[wakeThread] && (wakeData == CNT_W'(1)) && (cntQ == '0)); // R7

  AST_PARKED_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && blockedMask[reqThread]) |=> !respValid && !wakeValid && $stable(cntQ)); // R8

  AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> $stable(tagEmpty) && $stable(tagFull)); // R9
endmodule

bind semCell semCell_chk #(.TID_W(TID_W), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/semCell_tb_top.sv
`timescale 1ns/1ps
module semCell_tb_top;
  localparam int TID_W   = 2;
  localparam int CNT_W   = 16;
  localparam int THREADS = 1 << TID_W;
  localparam int MAXV    = 65535;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqTryView = 1'b0;
  logic [TID_W-1:0] reqThread = '0;
  logic [CNT_W-1:0] reqData = '0;
  logic respValid, respStall, wakeValid, tagEmpty, tagFull;
  logic [TID_W-1:0] respThread, wakeThread;
  logic [CNT_W-1:0] respData, wakeData;
  logic [THREADS-1:0] blockedMask;

  always #5 clk = ~clk;

  semCell #(.TID_W(TID_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqThread(reqThread),
    .reqWrite(reqWrite), .reqTryView(reqTryView), .reqData(reqData),
    .respValid(respValid), .respThread(respThread), .respStall(respStall),
    .respData(respData), .wakeValid(wakeValid), .wakeThread(wakeThread),
    .wakeData(wakeData), .blockedMask(blockedMask), .tagEmpty(tagEmpty),
    .tagFull(tagFull)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // behavioural reference state
  int refCnt = 0;
  int parked[$];  // parked thread ids

  task automatic chk(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int refMask();
    int m = 0;
    foreach (parked[i]) m |= (1 << parked[i]);
    return m;
  endfunction

  // one bus cycle: drive at negedge, model the edge, compare at next negedge
  task automatic step(string tag, bit v, int tid, bit wr, bit tryv, int data);
    bit eResp = 0, eStall = 0, eWake = 0;
    int eData = 0, eWakeTid = 0, low;
    reqValid = v; reqThread = TID_W'(tid); reqWrite = wr;
    reqTryView = tryv; reqData = CNT_W'(data);
    if (v && ((refMask() >> tid) & 1) == 0) begin
      eResp = 1;
      if (!wr) begin
        if (refCnt > 0) begin eData = refCnt; refCnt--; end
        else if (!tryv) begin eStall = 1; parked.push_back(tid); end
      end else if (parked.size() > 0) begin
        low = THREADS;
        foreach (parked[i]) if (parked[i] < low) low = parked[i];
        foreach (parked[i]) if (parked[i] == low) begin parked.delete(i); break; end
        eWake = 1; eWakeTid = low;
      end else if (refCnt < MAXV) refCnt++;
    end
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk(tag, "respValid", int'(respValid), int'(eResp));
    if (eResp) begin
      chk(tag, "respThread", int'(respThread), tid);
      chk(tag, "respStall", int'(respStall), int'(eStall));
      chk(tag, "respData", int'(respData), eData);
    end
    chk(tag, "wakeValid", int'(wakeValid), int'(eWake));
    if (eWake) begin
      chk(tag, "wakeThread", int'(wakeThread), eWakeTid);
      chk(tag, "wakeData", int'(wakeData), 1);
    end
    chk(tag, "blockedMask", int'(blockedMask), refMask());
    chk("R9", "tagEmpty", int'(tagEmpty), 1);
    chk("R9", "tagFull", int'(tagFull), 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "respValid", int'(respValid), 0);
    chk("R1", "wakeValid", int'(wakeValid), 0);
    chk("R1", "blockedMask", int'(blockedMask), 0);
    chk("R1", "tagEmpty", int'(tagEmpty), 1);
    chk("R1", "tagFull", int'(tagFull), 0);
    rstN = 1'b1;
    @(negedge clk);
    step("R1", 0, 0, 0, 0, 0);
    // R3: try read at zero
    step("R3", 1, 1, 0, 1, 0);
    // R5: writes with assorted data, each adds one
    step("R5", 1, 0, 1, 0, 16'hBEEF);
    step("R5", 1, 2, 1, 1, 16'h0000);
    step("R5", 1, 3, 1, 0, 16'hFFFF);
    // R2: reads in both views, back to back
    step("R2", 1, 2, 0, 0, 0);
    step("R2", 1, 3, 0, 1, 0);
    step("R2", 1, 0, 0, 0, 0);
    step("R3", 1, 0, 0, 1, 0);
    // R4: synchronized reads at zero park threads 3 then 1
    step("R4", 1, 3, 0, 0, 0);
    step("R4", 1, 1, 0, 0, 0);
    // R8: parked threads are ignored
    step("R8", 1, 3, 1, 0, 0);
    step("R8", 1, 1, 0, 1, 0);
    step("R8", 1, 2, 0, 1, 0);
    // R7: writes release lowest parked thread first
    step("R7", 1, 0, 1, 0, 7);
    step("R7", 1, 2, 0, 1, 0);
    step("R7", 1, 2, 1, 0, 0);
    step("R7", 1, 1, 0, 1, 0);
    // park again then release from a previously parked thread
    step("R4", 1, 2, 0, 0, 0);
    step("R7", 1, 3, 1, 1, 0);
    step("R2", 1, 0, 1, 0, 0);
    step("R2", 1, 1, 0, 0, 0);
    step("R1", 0, 0, 0, 0, 0);
    // R6: saturation at 0xFFFF
    for (int i = 0; i < MAXV + 2; i++) begin
      reqValid = 1'b1; reqThread = TID_W'(i % THREADS); reqWrite = 1'b1;
      reqTryView = 1'b0; reqData = CNT_W'(i);
      if (refCnt < MAXV) refCnt++;
      @(posedge clk);
      @(negedge clk);
    end
    reqValid = 1'b0;
    step("R6", 1, 2, 1, 0, 0);
    step("R6", 1, 1, 0, 1, 0);
    step("R6", 1, 1, 0, 0, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule